// File: doc/BRIEF.md
# Paced Configuration Port Bridge

This block carries 32-bit words between a memory-side streaming interface and a 32-bit configuration port. Words are carried in both directions. In the download direction, memory-side words enter a transmit FIFO and leave it as single-cycle write strobes on the configuration port. In the upload direction, words read back from the port enter a receive FIFO and are offered to the memory side through a valid/ready handshake.

A pacing unit decides how often a download word may be issued. In plain mode a word can go out on every clock. In quarter-rate mode at most one word goes out per four clocks, so that a byte-wide decryption and authentication path behind the port can keep up. The port works only when both the port-select and the reconfiguration-enable inputs are high. The two directions can run together, or a single direction can be chosen. The transmit and receive FIFOs report their fill levels and flags, and the transmit FIFO also reports a sticky overflow flag.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset both FIFOs are empty (levels 0, empty flags 1, full flags 0), `cfg_wr_stb` is 0 and `tx_overflow` is 0.
- R2: A word popped from the transmit FIFO appears on `cfg_wr_data` with `cfg_wr_stb` high for one cycle, one clock after the pop decision. Words leave in arrival order. In plain mode (`quarter_rate_en`=0) a new word can be issued on every clock.
- R3: The port is enabled only when `cfgport_sel`=1 and `reconf_en`=1. While it is disabled, no strobe is produced, the transmit FIFO keeps its contents and `cfg_rd_ready` is 0.
- R4: In quarter-rate mode a 2-bit pacing counter starts at 0 and advances on every clock. It is held at 0 while the mode is off. A word may issue only in a cycle where the counter is 0, so two strobes in quarter-rate mode are at least 4 cycles apart.
- R5: The transmit FIFO holds 32 words. A write offered while it is full is dropped and sets `tx_overflow`, which stays set until reset. The full test uses the level at the start of the cycle, so a write offered in the same cycle as a pop from a full FIFO is also dropped.
- R6: Port words with `cfg_rd_valid`&`cfg_rd_ready` enter the receive FIFO (32 words). They come out in order on `m_data` while `m_valid`=1, and one word is removed on each cycle with `m_valid`&`m_ready`.
- R7: With `concurrent_en`=1 both directions are active. With `concurrent_en`=0, `upload_sel`=0 activates only download and `upload_sel`=1 activates only upload. For an inactive download, `s_ready` is 0 and `s_valid` is ignored, with no write and no overflow. For an inactive upload, `cfg_rd_ready` is 0.
- R8: `tx_level`/`rx_level` give the current word counts. `tx_full`/`rx_full` are high exactly at 32 words and `tx_empty`/`rx_empty` exactly at 0. `s_ready` equals download-active AND NOT `tx_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgport_sel | input | 1 | Port mode select |
| reconf_en | input | 1 | Reconfiguration enable; port usable only with cfgport_sel |
| quarter_rate_en | input | 1 | One download word per four clocks |
| concurrent_en | input | 1 | Run both directions together |
| upload_sel | input | 1 | Single-direction choice: 0 download, 1 upload |
| s_valid | input | 1 | Memory-side download word valid |
| s_data | input | 32 | Memory-side download word |
| s_ready | output | 1 | Transmit FIFO can take a word |
| cfg_wr_stb | output | 1 | Port write strobe (registered) |
| cfg_wr_data | output | 32 | Port write word (registered) |
| cfg_rd_valid | input | 1 | Port read-back word valid |
| cfg_rd_data | input | 32 | Port read-back word |
| cfg_rd_ready | output | 1 | Receive FIFO accepts a port word |
| m_valid | output | 1 | Memory-side upload word valid |
| m_data | output | 32 | Memory-side upload word |
| m_ready | input | 1 | Memory side takes the upload word |
| tx_level | output | 6 | Transmit FIFO fill level |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_overflow | output | 1 | Sticky dropped-write flag |
| rx_level | output | 6 | Receive FIFO fill level |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |

## Verification
Two collisions are provoked. In the first, a memory-side write and a port-side pop land on the transmit FIFO in the same cycle while the FIFO is full. This is set up by filling it with the port disabled, then enabling the port while `s_valid` stays high. The dropped word and the set overflow flag are judged against a queue model. In the second, both directions run concurrently, with port reads pushed and memory-side reads popped on the receive FIFO in one cycle under a stalling `m_ready` pattern. The level and word order are compared each clock.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
  typedef struct packed {
    logic dl_act;
    logic ul_act;
  } dir_t;

  function automatic dir_t decode_dir(input logic concurrent, input logic up_sel);
    dir_t d;
    d.dl_act = concurrent | ~up_sel;
    d.ul_act = concurrent | up_sel;
    return d;
  endfunction
endpackage

// File: rtl/cpb_fifo.sv
module cpb_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  head,
  output logic [LW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] count_nx;
  logic          push, pop;

  assign push = wr_en && !full;
  assign pop  = rd_en && !empty;
  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_comb begin
    count_nx = count;
    if (push && !pop)      count_nx = count + LW'(1);
    else if (!push && pop) count_nx = count - LW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      count <= count_nx;
      full  <= (count_nx == LW'(DEPTH));
      empty <= (count_nx == '0);
    end
  end

  // R5
  full_blocks_push_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (count == LW'(DEPTH)));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: rtl/cpb_pacer.sv
module cpb_pacer #(
  parameter int DIV = 4,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic quarter_en,
  output logic slot
);
  logic [CW-1:0] cnt;

  assign slot = !quarter_en || (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (!quarter_en) cnt <= '0;
    else cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + CW'(1);
  end

  // R4
  pace_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (quarter_en && slot) |=> (!quarter_en || !slot));
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int DATA_W = 32,
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 32,
  parameter int PACE_DIV = 4,
  localparam int TX_LW = $clog2(TX_DEPTH + 1),
  localparam int RX_LW = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgport_sel,
  input  logic              reconf_en,
  input  logic              quarter_rate_en,
  input  logic              concurrent_en,
  input  logic              upload_sel,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              cfg_wr_stb,
  output logic [DATA_W-1:0] cfg_wr_data,
  input  logic              cfg_rd_valid,
  input  logic [DATA_W-1:0] cfg_rd_data,
  output logic              cfg_rd_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  input  logic              m_ready,
  output logic [TX_LW-1:0]  tx_level,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_overflow,
  output logic [RX_LW-1:0]  rx_level,
  output logic              rx_full,
  output logic              rx_empty
);
  import cpb_pkg::*;

  dir_t              dir;
  logic              port_en, slot;
  logic              tx_push_req, tx_pop, rx_push, rx_pop;
  logic [DATA_W-1:0] tx_head;

  assign dir     = decode_dir(concurrent_en, upload_sel);
  assign port_en = cfgport_sel && reconf_en;

  cpb_pacer #(.DIV(PACE_DIV)) pacer_i (
    .clk(clk), .rst(rst), .quarter_en(quarter_rate_en), .slot(slot)
  );

  // download path
  assign tx_push_req = s_valid && dir.dl_act;
  assign s_ready     = dir.dl_act && !tx_full;
  assign tx_pop      = port_en && dir.dl_act && !tx_empty && slot;

  cpb_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) tx_fifo_i (
    .clk(clk), .rst(rst),
    .wr_en(tx_push_req), .wr_data(s_data),
    .rd_en(tx_pop), .head(tx_head),
    .count(tx_level), .full(tx_full), .empty(tx_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_wr_stb  <= 1'b0;
      cfg_wr_data <= '0;
      tx_overflow <= 1'b0;
    end else begin
      cfg_wr_stb <= tx_pop;
      if (tx_pop) cfg_wr_data <= tx_head;
      if (tx_push_req && tx_full) tx_overflow <= 1'b1;
    end
  end

  // upload path
  assign cfg_rd_ready = port_en && dir.ul_act && !rx_full;
  assign rx_push      = cfg_rd_valid && cfg_rd_ready;
  assign m_valid      = !rx_empty;
  assign rx_pop       = m_ready;

  cpb_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) rx_fifo_i (
    .clk(clk), .rst(rst),
    .wr_en(rx_push), .wr_data(cfg_rd_data),
    .rd_en(rx_pop), .head(m_data),
    .count(rx_level), .full(rx_full), .empty(rx_empty)
  );

  // R3
  off_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> !cfg_wr_stb);

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!port_en && !s_valid) |=> $stable(tx_level));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tx_overflow |=> tx_overflow);
endmodule

// File: tb/cfg_port_bridge_tb_top.sv
`timescale 1ns/1ps
module cfg_port_bridge_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic cfgport_sel = 0, reconf_en = 0, quarter_rate_en = 0, concurrent_en = 0, upload_sel = 0;
  logic s_valid = 0, cfg_rd_valid = 0, m_ready = 0;
  logic [31:0] s_data = '0, cfg_rd_data = '0;
  logic s_ready, cfg_wr_stb, cfg_rd_ready, m_valid;
  logic [31:0] cfg_wr_data, m_data;
  logic [5:0] tx_level, rx_level;
  logic tx_full, tx_empty, tx_overflow, rx_full, rx_empty;

  cfg_port_bridge dut_i (
    .clk(clk), .rst(rst), .cfgport_sel(cfgport_sel), .reconf_en(reconf_en),
    .quarter_rate_en(quarter_rate_en), .concurrent_en(concurrent_en), .upload_sel(upload_sel),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .cfg_wr_stb(cfg_wr_stb), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_valid(cfg_rd_valid), .cfg_rd_data(cfg_rd_data), .cfg_rd_ready(cfg_rd_ready),
    .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
    .tx_level(tx_level), .tx_full(tx_full), .tx_empty(tx_empty), .tx_overflow(tx_overflow),
    .rx_level(rx_level), .rx_full(rx_full), .rx_empty(rx_empty)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  bit m_ovf = 0, e_stb = 0;
  int mcnt = 0;
  logic [31:0] e_wdata = '0;

  always @(posedge clk) begin : model
    bit pen, dl, ul, ok, txfull, rxfull, rxne;
    if (rst) begin
      txq.delete(); rxq.delete();
      m_ovf = 0; mcnt = 0; e_stb = 0; e_wdata = '0;
    end else begin
      pen = cfgport_sel && reconf_en;
      dl = concurrent_en || !upload_sel;
      ul = concurrent_en || upload_sel;
      ok = !quarter_rate_en || (mcnt == 0);
      mcnt = quarter_rate_en ? (mcnt + 1) % 4 : 0;
      txfull = (txq.size() == 32);
      e_stb = pen && dl && (txq.size() > 0) && ok;
      if (e_stb) e_wdata = txq.pop_front();
      if (s_valid && dl) begin
        if (txfull) m_ovf = 1;
        else txq.push_back(s_data);
      end
      rxfull = (rxq.size() == 32);
      rxne = (rxq.size() > 0);
      if (rxne && m_ready) void'(rxq.pop_front());
      if (cfg_rd_valid && pen && ul && !rxfull) rxq.push_back(cfg_rd_data);
    end
  end

  int cyc = 0, last_q = -1;
  always @(negedge clk) begin : compare
    bit dl, ul, pen;
    cyc++;
    if (!rst && !done) begin
      pen = cfgport_sel && reconf_en;
      dl = concurrent_en || !upload_sel;
      ul = concurrent_en || upload_sel;
      chk("R2", "cfg_wr_stb", cfg_wr_stb, e_stb);
      if (e_stb) chk("R2", "cfg_wr_data", cfg_wr_data, e_wdata);
      chk("R8", "tx_level", tx_level, txq.size());
      chk("R8", "tx_full", tx_full, txq.size() == 32);
      chk("R8", "tx_empty", tx_empty, txq.size() == 0);
      chk("R5", "tx_overflow", tx_overflow, m_ovf);
      chk("R6", "rx_level", rx_level, rxq.size());
      chk("R8", "rx_full", rx_full, rxq.size() == 32);
      chk("R8", "rx_empty", rx_empty, rxq.size() == 0);
      chk("R6", "m_valid", m_valid, rxq.size() > 0);
      if (rxq.size() > 0) chk("R6", "m_data", m_data, rxq[0]);
      chk("R7", "s_ready", s_ready, dl && (txq.size() < 32));
      chk("R7", "cfg_rd_ready", cfg_rd_ready, pen && ul && (rxq.size() < 32));
      if (!pen) chk("R3", "strobe while disabled", cfg_wr_stb, 0);
      if (!quarter_rate_en) last_q = -1;
      else if (cfg_wr_stb) begin
        if (last_q >= 0) chk("R4", "quarter strobe gap>=4", (cyc - last_q) >= 4, 1);
        last_q = cyc;
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL all watchdog actual=running expected=finished");
    done = 1;
    summary();
    $finish;
  end

  initial begin : stim
    repeat (3) tick();
    @(negedge clk);
    chk("R1", "reset strobe", cfg_wr_stb, 0);
    chk("R1", "reset tx_empty", tx_empty, 1);
    chk("R1", "reset rx_empty", rx_empty, 1);
    chk("R1", "reset tx_overflow", tx_overflow, 0);
    chk("R1", "reset levels", {tx_level, rx_level}, 0);
    tick();
    rst = 0;

    // R2 plain mode, back-to-back issue
    cfgport_sel = 1; reconf_en = 1; concurrent_en = 1;
    for (int i = 0; i < 8; i++) begin
      s_valid = 1; s_data = 32'hA000_0000 + i; tick();
    end
    s_valid = 0;
    repeat (12) tick();
    chk("R2", "tx drained", tx_level, 0);

    // R3 port disabled holds FIFO
    reconf_en = 0;
    for (int i = 0; i < 5; i++) begin
      s_valid = 1; s_data = 32'hB000_0000 + i; tick();
    end
    s_valid = 0;
    repeat (4) tick();
    chk("R3", "tx held with reconf_en=0", tx_level, 5);
    reconf_en = 1; cfgport_sel = 0;
    repeat (4) tick();
    chk("R3", "tx held with cfgport_sel=0", tx_level, 5);
    cfgport_sel = 1;
    repeat (10) tick();
    chk("R3", "tx drained after enable", tx_level, 0);

    // R4 quarter-rate pacing
    quarter_rate_en = 1;
    for (int i = 0; i < 10; i++) begin
      s_valid = 1; s_data = 32'hC000_0000 + i * 3; tick();
    end
    s_valid = 0;
    repeat (50) tick();
    chk("R4", "quarter drained", tx_level, 0);
    quarter_rate_en = 0;
    tick();

    // R5 overflow, write while full collides with pop
    reconf_en = 0;
    for (int i = 0; i < 34; i++) begin
      s_valid = 1; s_data = 32'hD000_0000 + i; tick();
    end
    s_valid = 0;
    @(negedge clk);
    chk("R5", "tx_full at 32", tx_full, 1);
    chk("R5", "overflow set", tx_overflow, 1);
    tick();
    reconf_en = 1;
    for (int i = 0; i < 3; i++) begin
      s_valid = 1; s_data = 32'hE000_0000 + i; tick();
    end
    s_valid = 0;
    repeat (40) tick();
    chk("R5", "overflow sticky", tx_overflow, 1);

    // R6 concurrent upload + download with stalls
    for (int i = 0; i < 24; i++) begin
      cfg_rd_valid = 1; cfg_rd_data = 32'h5000_0000 + i * 7;
      m_ready = (i % 3) != 0;
      s_valid = i[0]; s_data = 32'h6000_0000 + i;
      tick();
    end
    s_valid = 0; cfg_rd_valid = 0; m_ready = 1;
    repeat (30) tick();
    m_ready = 0;
    for (int i = 0; i < 34; i++) begin
      cfg_rd_valid = 1; cfg_rd_data = 32'h7000_0000 + i; tick();
    end
    cfg_rd_valid = 0;
    @(negedge clk);
    chk("R6", "rx_full at 32", rx_full, 1);
    tick();
    m_ready = 1;
    repeat (36) tick();
    m_ready = 0;

    // R7 single-direction modes
    concurrent_en = 0; upload_sel = 0;
    for (int i = 0; i < 4; i++) begin
      cfg_rd_valid = 1; cfg_rd_data = 32'h8000_0000 + i; tick();
    end
    cfg_rd_valid = 0;
    @(negedge clk);
    chk("R7", "upload ignored in download-only", rx_level, 0);
    tick();
    upload_sel = 1; reconf_en = 0;
    for (int i = 0; i < 4; i++) begin
      s_valid = 1; s_data = 32'h9000_0000 + i; tick();
    end
    s_valid = 0;
    @(negedge clk);
    chk("R7", "download ignored in upload-only", tx_level, 0);
    tick();
    reconf_en = 1;
    for (int i = 0; i < 4; i++) begin
      cfg_rd_valid = 1; cfg_rd_data = 32'h9100_0000 + i; tick();
    end
    cfg_rd_valid = 0; m_ready = 1;
    repeat (8) tick();

    // R1 reset clears sticky flag
    rst = 1; tick(); tick();
    rst = 0; tick();
    @(negedge clk);
    chk("R1", "overflow cleared by reset", tx_overflow, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule